// File: doc/BRIEF.md
# Page Table Walker

This block resolves address-translation misses in hardware. Two requesters, the instruction-fetch side and the load/store side, can each raise a walk request carrying a virtual page number. The walker arbitrates between them and latches the winning page number. It then reads one page-table entry per level through a single memory read port, starting from a root page number. The walk ends in one of three ways: a leaf entry with the level it was found at, a page fault for a malformed or missing translation, or an access fault reported by the memory port.

While a walk is in progress the walker holds a stall line to the pipeline. An access fault during a walk sends the controller through a separate one-cycle fault state, in which the stall is dropped and the fault is reported. The controller then returns to idle. A request that was waiting behind the faulted walk is therefore accepted and walked on its own merits. It never sees the previous fault.

Each level uses a 9-bit index into the virtual page number, and each entry is 8 bytes. An entry address is the page number of the current table, followed by the level's index, followed by three zero bits.

Top module: `ptw_walker`

## Requirements
- R1: Synchronous active-high reset leaves the walker idle, with `stall`, `walk_done`, `page_fault`, `access_fault` and `mem_req_valid` all low.
- R2: The first read of a walk targets `{root_ppn, vpn[26:18], 3'b000}`. `mem_req_valid` stays high, with a stable address, until a cycle in which `mem_req_ready` is high.
- R3: `stall` is high from the cycle a request is accepted through every cycle of the walk. It is low in the cycle that reports the outcome, and low while idle with no request.
- R4: An entry is a leaf when V (bit 0) is set and any of R (bit 1), W (bit 2) or X (bit 3) is set. A leaf ends the walk with a single-cycle `walk_done` pulse. `walk_pte` then carries the entry, `walk_level` the level it was read at (2 is the root level), and `walk_src` the requester.
- R5: A valid entry that is not a leaf and was read above level 0 gives the next read address `{pte[10 +: PPN_W], index of the next lower level, 3'b000}`. Exactly one read is made per level visited.
- R6: An entry with V=0, or with R=0 and W=1, ends the walk with a single-cycle `page_fault` pulse and no `walk_done`.
- R7: A valid entry that is not a leaf and was read at level 0 ends the walk with a `page_fault` pulse.
- R8: A read response with `mem_rsp_fault` high moves the walker into a fault state for exactly one cycle. In that cycle `access_fault` is high and `stall` is low. The walker is idle on the next cycle.
- R9: A request held pending while a walk ends in an access fault is accepted once the walker returns to idle. It gets a complete walk of its own and its own outcome.
- R10: When both requesters ask in the same idle cycle, the load/store side is served first (`walk_src` = 1). The instruction-fetch side is served next.
- R11: A request raised while a walk is in progress has no effect on that walk's reads or outcome.
- R12: Reset asserted in the middle of a walk abandons it. The walker returns to idle with no request on the memory port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Instruction-fetch walk request, held until its outcome |
| fetch_vpn | input | VPN_W*LEVELS | Virtual page number for the fetch request |
| ldst_req | input | 1 | Load/store walk request, held until its outcome |
| ldst_vpn | input | VPN_W*LEVELS | Virtual page number for the load/store request |
| root_ppn | input | PPN_W | Page number of the root table |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | PPN_W+VPN_W+3 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 64 | Entry returned by memory |
| mem_rsp_fault | input | 1 | The read caused an access fault |
| stall | output | 1 | Pipeline stall while a walk is in progress |
| walk_done | output | 1 | One-cycle pulse: a leaf was found |
| walk_pte | output | 64 | Last entry read |
| walk_level | output | LVL_W | Level of the last entry read |
| walk_src | output | 1 | Requester of the current walk (1 = load/store) |
| page_fault | output | 1 | One-cycle pulse: translation page fault |
| access_fault | output | 1 | One-cycle pulse: memory access fault during the walk |

## Verification
The bench builds the walker with three levels of 9-bit indices and a 12-bit physical page number, which gives 24-bit entry addresses. At that width the bench model computes every table entry and every expected address arithmetically from the page number, the level and the requester. The sweep covers leaf, invalid and reserved-encoding entries at each of the three levels. It also covers access faults at each level, a walk that never finds a leaf, both requesters, and two ready patterns. Directed sequences add a request pending behind a faulting walk, simultaneous requests and reset in the middle of a walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_FAULT = 2'd2,
    ST_DONE  = 2'd3
  } walk_state_e;

  localparam int ENTRY_W     = 64;
  localparam int ENTRY_SHIFT = 3;
  localparam int PPN_LSB     = 10;

  localparam int FLAG_V = 0;
  localparam int FLAG_R = 1;
  localparam int FLAG_W = 2;
  localparam int FLAG_X = 3;

  // Any access permission marks the end of the walk.
  function automatic logic entry_is_leaf(input logic [3:0] flags);
    return flags[FLAG_R] | flags[FLAG_W] | flags[FLAG_X];
  endfunction

  // Missing translation or reserved write-only encoding.
  function automatic logic entry_is_malformed(input logic [3:0] flags);
    return !flags[FLAG_V] || (!flags[FLAG_R] && flags[FLAG_W]);
  endfunction

endpackage

// File: rtl/ptw_req_arb.sv
module ptw_req_arb #(
  parameter int VA_VPN_W = 27
) (
  input  logic                fetch_req,
  input  logic [VA_VPN_W-1:0] fetch_vpn,
  input  logic                ldst_req,
  input  logic [VA_VPN_W-1:0] ldst_vpn,
  output logic                any_req,
  output logic                pick_ldst,
  output logic [VA_VPN_W-1:0] pick_vpn
);

  // Load/store wins a tie; fetch is served once it drops its request.
  always_comb begin
    any_req   = fetch_req | ldst_req;
    pick_ldst = ldst_req;
    pick_vpn  = ldst_req ? ldst_vpn : fetch_vpn;
  end

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int PPN_W  = 44,
  parameter int VPN_W  = 9,
  parameter int LEVELS = 3,
  parameter int LVL_W  = 2
) (
  input  logic [PPN_W-1:0]                       table_ppn,
  input  logic [VPN_W*LEVELS-1:0]                vpn,
  input  logic [LVL_W-1:0]                       level,
  output logic [PPN_W+VPN_W+ptw_pkg::ENTRY_SHIFT-1:0] entry_addr
);

  localparam int VA_VPN_W = VPN_W * LEVELS;
  localparam int PA_W     = PPN_W + VPN_W + ptw_pkg::ENTRY_SHIFT;

  function automatic logic [PA_W-1:0] form_entry_addr(
    input logic [PPN_W-1:0]    ppn,
    input logic [VA_VPN_W-1:0] full_vpn,
    input logic [LVL_W-1:0]    lvl
  );
    logic [VPN_W-1:0] idx;
    idx = full_vpn[int'(lvl)*VPN_W +: VPN_W];
    return {ppn, idx, {ptw_pkg::ENTRY_SHIFT{1'b0}}};
  endfunction

  always_comb entry_addr = form_entry_addr(table_ppn, vpn, level);

endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check #(
  parameter int PPN_W = 44,
  parameter int LVL_W = 2
) (
  input  logic [3:0]       flags,
  input  logic [PPN_W-1:0] ppn_field,
  input  logic [LVL_W-1:0] level,
  output logic             is_leaf,
  output logic             is_bad,
  output logic             bottom_nonleaf,
  output logic [PPN_W-1:0] next_ppn
);

  always_comb begin
    is_bad         = ptw_pkg::entry_is_malformed(flags);
    is_leaf        = !is_bad && ptw_pkg::entry_is_leaf(flags);
    bottom_nonleaf = !is_bad && !ptw_pkg::entry_is_leaf(flags) && (level == '0);
    next_ppn       = ppn_field;
  end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int PPN_W  = 44,
  parameter int VPN_W  = 9,
  parameter int LEVELS = 3,
  parameter int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   fetch_req,
  input  logic [VPN_W*LEVELS-1:0]                fetch_vpn,
  input  logic                                   ldst_req,
  input  logic [VPN_W*LEVELS-1:0]                ldst_vpn,
  input  logic [PPN_W-1:0]                       root_ppn,
  output logic                                   mem_req_valid,
  input  logic                                   mem_req_ready,
  output logic [PPN_W+VPN_W+3-1:0]               mem_req_addr,
  input  logic                                   mem_rsp_valid,
  input  logic [63:0]                            mem_rsp_data,
  input  logic                                   mem_rsp_fault,
  output logic                                   stall,
  output logic                                   walk_done,
  output logic [63:0]                            walk_pte,
  output logic [LVL_W-1:0]                       walk_level,
  output logic                                   walk_src,
  output logic                                   page_fault,
  output logic                                   access_fault
);

  import ptw_pkg::*;

  localparam int VA_VPN_W = VPN_W * LEVELS;
  localparam int PA_W     = PPN_W + VPN_W + ENTRY_SHIFT;
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

  walk_state_e          state_q;
  logic [LVL_W-1:0]     lvl_q;
  logic [VA_VPN_W-1:0]  vpn_q;
  logic                 src_q;
  logic                 issued_q;
  logic [PA_W-1:0]      addr_q;
  logic [ENTRY_W-1:0]   pte_q;
  logic                 pf_q;

  // Named internal events.
  logic in_idle, in_wait, in_fault, in_done;
  logic any_req, pick_ldst;
  logic [VA_VPN_W-1:0] pick_vpn;
  logic accept, rsp_take, rsp_ok;
  logic end_afault, end_bad, end_leaf, step_down;
  logic is_leaf, is_bad, bottom_nonleaf;
  logic [PPN_W-1:0] next_ppn;
  logic [PPN_W-1:0] gen_ppn;
  logic [VA_VPN_W-1:0] gen_vpn;
  logic [LVL_W-1:0] gen_lvl;
  logic [PA_W-1:0] gen_addr;

  assign in_idle  = (state_q == ST_IDLE);
  assign in_wait  = (state_q == ST_WAIT);
  assign in_fault = (state_q == ST_FAULT);
  assign in_done  = (state_q == ST_DONE);

  ptw_req_arb #(.VA_VPN_W(VA_VPN_W)) u_arb (
    .fetch_req (fetch_req),
    .fetch_vpn (fetch_vpn),
    .ldst_req  (ldst_req),
    .ldst_vpn  (ldst_vpn),
    .any_req   (any_req),
    .pick_ldst (pick_ldst),
    .pick_vpn  (pick_vpn)
  );

  ptw_pte_check #(.PPN_W(PPN_W), .LVL_W(LVL_W)) u_check (
    .flags          (mem_rsp_data[3:0]),
    .ppn_field      (mem_rsp_data[PPN_LSB +: PPN_W]),
    .level          (lvl_q),
    .is_leaf        (is_leaf),
    .is_bad         (is_bad),
    .bottom_nonleaf (bottom_nonleaf),
    .next_ppn       (next_ppn)
  );

  // One address former serves both the first read and every descent.
  assign gen_ppn = in_idle ? root_ppn : next_ppn;
  assign gen_vpn = in_idle ? pick_vpn : vpn_q;
  assign gen_lvl = in_idle ? TOP_LVL  : (lvl_q - LVL_W'(1));

  ptw_addr_gen #(.PPN_W(PPN_W), .VPN_W(VPN_W), .LEVELS(LEVELS), .LVL_W(LVL_W)) u_addr (
    .table_ppn  (gen_ppn),
    .vpn        (gen_vpn),
    .level      (gen_lvl),
    .entry_addr (gen_addr)
  );

  assign accept     = in_idle & any_req;
  assign rsp_take   = in_wait & issued_q & mem_rsp_valid;
  assign end_afault = rsp_take & mem_rsp_fault;
  assign rsp_ok     = rsp_take & !mem_rsp_fault;
  assign end_bad    = rsp_ok & (is_bad | bottom_nonleaf);
  assign end_leaf   = rsp_ok & is_leaf;
  assign step_down  = rsp_ok & !is_bad & !is_leaf & !bottom_nonleaf;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      lvl_q    <= '0;
      vpn_q    <= '0;
      src_q    <= 1'b0;
      issued_q <= 1'b0;
      addr_q   <= '0;
      pte_q    <= '0;
      pf_q     <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q  <= ST_WAIT;
            lvl_q    <= TOP_LVL;
            vpn_q    <= pick_vpn;
            src_q    <= pick_ldst;
            issued_q <= 1'b0;
            addr_q   <= gen_addr;
          end
        end
        ST_WAIT: begin
          if (mem_req_valid && mem_req_ready) issued_q <= 1'b1;
          if (end_afault) begin
            state_q <= ST_FAULT;
          end else if (end_bad) begin
            state_q <= ST_DONE;
            pf_q    <= 1'b1;
            pte_q   <= mem_rsp_data;
          end else if (end_leaf) begin
            state_q <= ST_DONE;
            pf_q    <= 1'b0;
            pte_q   <= mem_rsp_data;
          end else if (step_down) begin
            lvl_q    <= lvl_q - LVL_W'(1);
            addr_q   <= gen_addr;
            issued_q <= 1'b0;
          end
        end
        ST_FAULT: state_q <= ST_IDLE;
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid = in_wait & !issued_q;
  assign mem_req_addr  = addr_q;
  assign stall         = accept | in_wait;
  assign walk_done     = in_done & !pf_q;
  assign page_fault    = in_done & pf_q;
  assign access_fault  = in_fault;
  assign walk_pte      = pte_q;
  assign walk_level    = lvl_q;
  assign walk_src      = src_q;

  // Assertions
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_wait_stalls_R3: assert property (@(posedge clk) disable iff (rst)
    in_wait |-> stall);

  assert_one_outcome_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({walk_done, page_fault, access_fault}));

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    walk_done |=> !walk_done);

  assert_level_bounded_R5: assert property (@(posedge clk) disable iff (rst)
    in_wait |-> (lvl_q <= TOP_LVL));

  assert_pf_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    page_fault |=> !page_fault);

  assert_fault_nostall_R8: assert property (@(posedge clk) disable iff (rst)
    access_fault |-> !stall);

  assert_fault_to_idle_R8: assert property (@(posedge clk) disable iff (rst)
    access_fault |=> in_idle);

  assert_after_fault_accept_R9: assert property (@(posedge clk) disable iff (rst)
    (in_idle && any_req) |-> stall);

  assert_ldst_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (accept && ldst_req) |=> walk_src);

  assert_busy_ignores_R11: assert property (@(posedge clk) disable iff (rst)
    (in_wait && !step_down) |=> $stable(mem_req_addr));

endmodule

// File: tb/ptw_walker_tb.sv
`timescale 1ns/100ps
module ptw_walker_tb;

  localparam int PPN_W = 12;
  localparam int VPN_W = 9;
  localparam int LEVELS = 3;
  localparam int VA = VPN_W * LEVELS;
  localparam int PA = PPN_W + VPN_W + 3;
  localparam int TOP = LEVELS - 1;

  localparam int K_LEAF = 0;
  localparam int K_INV  = 1;
  localparam int K_RWB  = 2;
  localparam int K_AF   = 3;
  localparam int K_NL0  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          fetch_req, ldst_req;
  logic [VA-1:0] fetch_vpn, ldst_vpn;
  logic [PPN_W-1:0] root_ppn;
  logic          mem_req_valid, mem_req_ready;
  logic [PA-1:0] mem_req_addr;
  logic          mem_rsp_valid, mem_rsp_fault;
  logic [63:0]   mem_rsp_data;
  logic          stall, walk_done, walk_src, page_fault, access_fault;
  logic [63:0]   walk_pte;
  logic [1:0]    walk_level;

  ptw_walker #(.PPN_W(PPN_W), .VPN_W(VPN_W), .LEVELS(LEVELS)) u_dut (
    .clk(clk), .rst(rst),
    .fetch_req(fetch_req), .fetch_vpn(fetch_vpn),
    .ldst_req(ldst_req), .ldst_vpn(ldst_vpn),
    .root_ppn(root_ppn),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_fault(mem_rsp_fault),
    .stall(stall), .walk_done(walk_done), .walk_pte(walk_pte), .walk_level(walk_level),
    .walk_src(walk_src), .page_fault(page_fault), .access_fault(access_fault)
  );

  int n_chk = 0;
  int n_bad = 0;
  int sc_kind [2];
  int sc_lvl  [2];
  logic [VA-1:0] cur_vpn [2];
  int rd_count = 0;
  int ready_mode = 0;
  int cyc = 0;
  bit pend = 0;
  bit pend_fault = 0;
  logic [63:0] pend_data = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [PPN_W-1:0] nl_ppn(input int src, input int lvl, input logic [VA-1:0] vpn);
    return PPN_W'(int'(vpn) * 7 + lvl * 333 + src * 5 + 1);
  endfunction

  function automatic logic [PA-1:0] exp_addr(input logic [PPN_W-1:0] ppn, input logic [VA-1:0] vpn, input int lvl);
    int idx;
    idx = (int'(vpn) >> (lvl * VPN_W)) % 512;
    return PA'(int'(ppn) * 4096 + idx * 8);
  endfunction

  function automatic logic [63:0] leaf_pte(input int src, input int lvl, input logic [VA-1:0] vpn);
    logic [PPN_W-1:0] ppn;
    logic [3:0] fl;
    ppn = PPN_W'(int'(vpn) * 3 + lvl * 11 + src);
    case (int'(vpn) % 5)
      0: fl = 4'b0010;
      1: fl = 4'b0110;
      2: fl = 4'b1000;
      3: fl = 4'b1010;
      default: fl = 4'b1110;
    endcase
    return (64'(ppn) << 10) | 64'(fl) | 64'd1 | (64'(lvl) << 8);
  endfunction

  // Memory model: entries and expected addresses derived arithmetically.
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_fault = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid = 1'b0;
      mem_rsp_fault = 1'b0;
      if (rst) begin
        pend = 0;
        rd_count = 0;
        mem_req_ready = 1'b0;
      end else begin
        if (pend) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_fault = pend_fault;
          mem_rsp_data  = pend_data;
          pend = 0;
        end
        mem_req_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
        if (mem_req_valid && mem_req_ready) begin
          int s, lv, k;
          logic [VA-1:0] v;
          logic [PA-1:0] ea;
          s  = int'(walk_src);
          v  = cur_vpn[s];
          lv = TOP - rd_count;
          k  = sc_kind[s];
          ea = (lv == TOP) ? exp_addr(root_ppn, v, lv) : exp_addr(nl_ppn(s, lv + 1, v), v, lv);
          // R2 (root read) and R5 (descent reads)
          chk(mem_req_addr == ea, (lv == TOP) ? "R2" : "R5", "entry address",
              longint'(mem_req_addr), longint'(ea));
          pend_fault = 1'b0;
          if (k == K_AF && lv == sc_lvl[s]) begin
            pend_fault = 1'b1;
            pend_data  = '0;
          end else if (k == K_NL0 || lv > sc_lvl[s]) begin
            pend_data = (64'(nl_ppn(s, lv, v)) << 10) | 64'd1;
          end else if (k == K_LEAF) begin
            pend_data = leaf_pte(s, lv, v);
          end else if (k == K_INV) begin
            pend_data = (64'(nl_ppn(s, lv, v)) << 10) | 64'b0110;
          end else begin
            pend_data = (64'(nl_ppn(s, lv, v)) << 10) | 64'b0101;
          end
          pend = 1;
          rd_count++;
        end
      end
    end
  end

  task automatic set_req(input int src, input logic [VA-1:0] vpn, input int kind, input int lvl);
    sc_kind[src] = kind;
    sc_lvl[src]  = lvl;
    cur_vpn[src] = vpn;
    if (src == 1) begin ldst_vpn = vpn; ldst_req = 1'b1; end
    else begin fetch_vpn = vpn; fetch_req = 1'b1; end
  endtask

  task automatic drop_req(input int src);
    if (src == 1) ldst_req = 1'b0; else fetch_req = 1'b0;
  endtask

  task automatic wait_outcome(output int oc, output logic [63:0] pte, output int lvl,
                              output int src, output bit sok, output int reads);
    oc = 0; sok = 1; pte = '0; lvl = -1; src = -1; reads = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); #1;
      if (walk_done || page_fault || access_fault) begin
        oc    = walk_done ? 1 : (page_fault ? 2 : 3);
        pte   = walk_pte;
        lvl   = int'(walk_level);
        src   = int'(walk_src);
        reads = rd_count;
        rd_count = 0;
        if (stall) sok = 0;
        break;
      end
      if (!stall) sok = 0;
    end
    if (oc == 0) chk(0, "R3", "walk timed out", 0, 1);
  endtask

  task automatic check_outcome(input int src, input logic [VA-1:0] vpn, input int kind, input int lvl,
                               input int oc, input logic [63:0] pte, input int olv,
                               input int osrc, input bit sok, input int reads);
    int eoc, ereads;
    string tag;
    case (kind)
      K_LEAF: begin eoc = 1; tag = "R4"; end
      K_INV, K_RWB: begin eoc = 2; tag = "R6"; end
      K_NL0: begin eoc = 2; tag = "R7"; end
      default: begin eoc = 3; tag = "R8"; end
    endcase
    ereads = (kind == K_NL0) ? LEVELS : (TOP - lvl + 1);
    chk(sok, "R3", "stall high during walk and low at outcome", longint'(sok), 1);
    chk(oc == eoc, tag, "outcome kind", oc, eoc);
    chk(osrc == src, "R4", "walk_src", osrc, src);
    chk(reads == ereads, "R5", "reads per walk", reads, ereads);
    if (kind == K_LEAF) begin
      chk(pte == leaf_pte(src, lvl, vpn), "R4", "walk_pte", longint'(pte), longint'(leaf_pte(src, lvl, vpn)));
      chk(olv == lvl, "R4", "walk_level", olv, lvl);
    end
  endtask

  task automatic run_walk(input int src, input logic [VA-1:0] vpn, input int kind, input int lvl);
    int oc, olv, osrc, reads;
    logic [63:0] opte;
    bit sok;
    @(negedge clk); #1;
    set_req(src, vpn, kind, lvl);
    #0.5;
    chk(stall, "R3", "stall in accept cycle", longint'(stall), 1);
    wait_outcome(oc, opte, olv, osrc, sok, reads);
    drop_req(src);
    check_outcome(src, vpn, kind, lvl, oc, opte, olv, osrc, sok, reads);
    if (oc == 1 || oc == 2) begin
      @(negedge clk); #1;
      chk(!walk_done && !page_fault, (oc == 1) ? "R4" : "R6", "outcome lasts one cycle",
          longint'({walk_done, page_fault}), 0);
    end
    if (kind == K_AF) begin
      @(negedge clk); #1;
      chk(!stall && !access_fault && !mem_req_valid, "R8", "idle after fault cycle",
          longint'({stall, access_fault, mem_req_valid}), 0);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL R3 watchdog expired: actual hung expected finished");
    finish_run();
  end

  initial begin
    fetch_req = 1'b0; ldst_req = 1'b0;
    fetch_vpn = '0; ldst_vpn = '0;
    root_ppn  = 12'h5A3;
    sc_kind[0] = K_LEAF; sc_kind[1] = K_LEAF;
    sc_lvl[0] = 0; sc_lvl[1] = 0;
    cur_vpn[0] = '0; cur_vpn[1] = '0;
    repeat (3) @(negedge clk);
    #1;
    rst = 1'b0;
    @(negedge clk); #1;
    // R1: reset state
    chk(!stall && !walk_done && !page_fault && !access_fault && !mem_req_valid, "R1",
        "outputs after reset", longint'({stall, walk_done, page_fault, access_fault, mem_req_valid}), 0);

    // Sweep: requester x outcome kind x level x page number x ready pattern.
    for (int src = 0; src < 2; src++) begin
      for (int v = 0; v < 4; v++) begin
        logic [VA-1:0] vpn;
        ready_mode = v % 2;
        for (int kind = 0; kind < 4; kind++) begin
          for (int lvl = TOP; lvl >= 0; lvl--) begin
            vpn = VA'(v * 32'h2D1A7 + src * 12345 + lvl * 999 + kind * 77 + 3);
            run_walk(src, vpn, kind, lvl);
          end
        end
        vpn = VA'(v * 32'h1F3B5 + src * 4321 + 11);
        run_walk(src, vpn, K_NL0, 0);
      end
    end

    // R9 / R11: load/store raised mid-walk behind a fetch walk that access-faults.
    begin
      int oc, olv, osrc, reads;
      logic [63:0] opte;
      bit sok;
      ready_mode = 1;
      @(negedge clk); #1;
      set_req(0, VA'(27'h0ABCDE), K_AF, 1);
      repeat (2) @(negedge clk);
      #1;
      set_req(1, VA'(27'h3456789), K_LEAF, 0);
      wait_outcome(oc, opte, olv, osrc, sok, reads);
      drop_req(0);
      chk(oc == 3, "R8", "first walk access fault", oc, 3);
      chk(osrc == 0, "R11", "busy walk keeps its requester", osrc, 0);
      chk(reads == 2, "R11", "busy walk reads", reads, 2);
      wait_outcome(oc, opte, olv, osrc, sok, reads);
      drop_req(1);
      chk(oc == 1, "R9", "pending request walked after fault", oc, 1);
      chk(osrc == 1, "R9", "pending request source", osrc, 1);
      chk(reads == 3, "R9", "full walk after fault", reads, 3);
      chk(sok, "R9", "stall through second walk", longint'(sok), 1);
      chk(opte == leaf_pte(1, 0, VA'(27'h3456789)), "R9", "second walk entry",
          longint'(opte), longint'(leaf_pte(1, 0, VA'(27'h3456789))));
    end

    // R10: simultaneous requests.
    begin
      int oc, olv, osrc, reads;
      logic [63:0] opte;
      bit sok;
      ready_mode = 0;
      @(negedge clk); #1;
      set_req(0, VA'(27'h1111111), K_LEAF, 1);
      set_req(1, VA'(27'h2222222), K_LEAF, 2);
      wait_outcome(oc, opte, olv, osrc, sok, reads);
      drop_req(1);
      chk(osrc == 1 && oc == 1, "R10", "load/store served first", osrc, 1);
      wait_outcome(oc, opte, olv, osrc, sok, reads);
      drop_req(0);
      chk(osrc == 0 && oc == 1, "R10", "fetch served second", osrc, 0);
      chk(olv == 1, "R10", "fetch walk level", olv, 1);
    end

    // R12: reset in the middle of a walk.
    ready_mode = 1;
    @(negedge clk); #1;
    set_req(0, VA'(27'h0777777), K_LEAF, 0);
    repeat (3) @(negedge clk);
    #1;
    rst = 1'b1;
    drop_req(0);
    @(negedge clk); #1;
    rst = 1'b0;
    chk(!stall && !mem_req_valid && !walk_done && !page_fault && !access_fault, "R12",
        "idle after mid-walk reset", longint'({stall, mem_req_valid, walk_done, page_fault, access_fault}), 0);
    run_walk(1, VA'(27'h0123456), K_LEAF, 0);

    finish_run();
  end

endmodule